// File: doc/BRIEF.md
# Multiplexer-Based Configurable Logic Cell

This block is a fine-grain programmable logic cell. Its logic is built only from 2:1 multiplexers and one OR gate. Two first-level multiplexers, called function wheels, each pick between two data pins under a select pin. A final multiplexer then chooses between the two wheels. The select of the final multiplexer is the OR of two further select pins. Each of the eight pins has its own 2-bit source code. The code ties the pin to constant 0, to constant 1, or to one of the two live variables wired to that pin's group.

A function is mapped onto the cell by Shannon expansion. The designer splits a function about one variable and routes that variable to a select pin. The two cofactors are then realised in the wheels. The cell is not programmed from a truth table.

A configuration word is loaded through a parallel write port with a write strobe. One bit of that word chooses the output: the combinational result, or the result held in a positive-edge storage element. The storage element has an asynchronous active-high clear.

Top module: `lm_cell`

## Requirements
- R1: A function wheel outputs its first data pin when its select pin is 0 and its second data pin when its select pin is 1.
- R2: A pin source code of 0 drives constant 0 and code 1 drives constant 1. Code 2 drives bit 0 of the pin group's variable input and code 3 drives bit 1. Wheel A's pins read `wa_var`, wheel B's pins read `wb_var`, and the two output-select pins read `sel_var`.
- R3: The combinational output `f_comb` equals wheel B when either output-select pin is 1, and wheel A when both are 0.
- R4: Wheel A is set to (D, 1, select C) and wheel B to (D, 1, select A). The first output-select pin is tied to 0 and the second is driven by B. With this setup, `f_comb` equals A·B + B'·C + D for all 16 input combinations.
- R5: Splitting a function about A gives every one of the 16 functions of two variables. Variable A drives one output-select pin. Each wheel holds one cofactor in B.
- R6: A two-input NAND is obtained as follows. One wheel inverts B and the other wheel is tied to 1. The output select is driven by A, and the second select pin is tied to 0.
- R7: The configuration word is replaced at a rising clock edge where `cfg_we` is 1. It is kept unchanged at every edge where `cfg_we` is 0. Field layout of `cfg_wdata`, least significant first, 2 bits each: wheel A data0 [1:0], data1 [3:2], select [5:4]; wheel B data0 [7:6], data1 [9:8], select [11:10]; output select low [13:12], high [15:14]. Bit 16 chooses registered output.
- R8: A synchronous reset clears the configuration word to all zeros. This gives `f_comb` = 0 and combinational output mode.
- R9: When bit 16 is 1, `f_out` shows the value `f_comb` had at the previous rising clock edge. If the configuration word is rewritten at that same edge, the captured value comes from the old configuration.
- R10: While `clr` is 1, the stored value is 0 at once, without waiting for a clock edge. A rising clock edge during clear does not load it.
- R11: When bit 16 is 0, `f_out` follows `f_comb` in the same cycle.
- R12: A single wheel, with both output-select pins at 0, gives INV, BUF, AND, OR, A·B' and A'·B of its two variables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register and the storage element |
| rst | input | 1 | Synchronous active-high reset of the configuration word |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 17 | New configuration word |
| clr | input | 1 | Asynchronous active-high clear of the storage element |
| wa_var | input | 2 | Live variables available to wheel A pins |
| wb_var | input | 2 | Live variables available to wheel B pins |
| sel_var | input | 2 | Live variables available to the output-select pins |
| f_comb | output | 1 | Combinational cell result |
| f_out | output | 1 | Cell output, registered or combinational by mode |

## Verification
Two functions can land on the same rising edge. The storage element can capture while the configuration word is being rewritten. The asynchronous clear can also be held across a clock edge that would otherwise load a 1. The bench provokes the first case with a write strobe in registered mode, timed so that the old configuration drives a 1 and the new one drives a 0. It passes only if the register shows the old configuration's value for one cycle. It provokes the second case by raising `clr` between edges, holding it through an edge, and releasing it between edges. It passes only if the output stays 0 until the first edge after release.

// File: rtl/lm_pkg.sv
`timescale 1ns/1ps
package lm_pkg;

    localparam int VARS_PER_PIN = 2;
    localparam int SRC_W        = $clog2(VARS_PER_PIN + 2);
    localparam int N_WHEELS     = 2;
    localparam int PINS_WHEEL   = 3;
    localparam int N_SEL_PINS   = 2;
    localparam int N_PINS       = N_WHEELS * PINS_WHEEL + N_SEL_PINS;
    localparam int CFG_W        = N_PINS * SRC_W + 1;

    typedef enum logic [SRC_W-1:0] {
        SRC_ZERO = 2'd0,
        SRC_ONE  = 2'd1,
        SRC_VAR0 = 2'd2,
        SRC_VAR1 = 2'd3
    } src_e;

    // data0 sits in the low bits of each wheel group
    typedef struct packed {
        src_e sel;
        src_e dat1;
        src_e dat0;
    } wheel_cfg_t;

    typedef struct packed {
        logic       registered;
        src_e       sel_hi;
        src_e       sel_lo;
        wheel_cfg_t wheel_b;
        wheel_cfg_t wheel_a;
    } cell_cfg_t;

    function automatic logic resolve_src(input src_e code,
                                         input logic [VARS_PER_PIN-1:0] vars);
        logic r;
        case (code)
            SRC_ZERO: r = 1'b0;
            SRC_ONE:  r = 1'b1;
            SRC_VAR0: r = vars[0];
            default:  r = vars[1];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lm_pin_src.sv
`timescale 1ns/1ps
module lm_pin_src
    import lm_pkg::*;
(
    input  src_e                    code,
    input  logic [VARS_PER_PIN-1:0] vars,
    output logic                    pin
);
    always_comb pin = resolve_src(code, vars);
endmodule

// File: rtl/lm_wheel.sv
`timescale 1ns/1ps
module lm_wheel
    import lm_pkg::*;
(
    input  wheel_cfg_t              cfg,
    input  logic [VARS_PER_PIN-1:0] vars,
    output logic                    y
);
    src_e                  codes [PINS_WHEEL];
    logic [PINS_WHEEL-1:0] pins;

    always_comb begin
        codes[0] = cfg.dat0;
        codes[1] = cfg.dat1;
        codes[2] = cfg.sel;
    end

    for (genvar p = 0; p < PINS_WHEEL; p++) begin : g_pin
        lm_pin_src i_src (
            .code (codes[p]),
            .vars (vars),
            .pin  (pins[p])
        );
    end

    // pins[2] is the select, pins[1:0] the data pins
    always_comb y = pins[2] ? pins[1] : pins[0];
endmodule

// File: rtl/lm_seq_elem.sv
`timescale 1ns/1ps
module lm_seq_elem (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or posedge clr) begin
        if (clr) q <= 1'b0;
        else     q <= d;
    end

    // R10
    clear_hold_chk: assert property (@(posedge clk) clr |-> (q == 1'b0))
        else $error("stored value not zero while clear held");

    // R9
    capture_chk: assert property (@(posedge clk) disable iff (rst || clr)
        1'b1 |=> (q == $past(d)))
        else $error("storage element did not capture its input");
endmodule

// File: rtl/lm_cell.sv
`timescale 1ns/1ps
module lm_cell
    import lm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [CFG_W-1:0]        cfg_wdata,
    input  logic                    clr,
    input  logic [VARS_PER_PIN-1:0] wa_var,
    input  logic [VARS_PER_PIN-1:0] wb_var,
    input  logic [VARS_PER_PIN-1:0] sel_var,
    output logic                    f_comb,
    output logic                    f_out
);
    cell_cfg_t                 cfg_q;
    wheel_cfg_t                wheel_cfg [N_WHEELS];
    logic [VARS_PER_PIN-1:0]   wheel_vars [N_WHEELS];
    logic [N_WHEELS-1:0]       wheel_y;
    src_e                      sel_codes [N_SEL_PINS];
    logic [N_SEL_PINS-1:0]     sel_pins;
    logic                      sel_or;
    logic                      q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cell_cfg_t'(cfg_wdata);
    end

    always_comb begin
        wheel_cfg[0]  = cfg_q.wheel_a;
        wheel_cfg[1]  = cfg_q.wheel_b;
        wheel_vars[0] = wa_var;
        wheel_vars[1] = wb_var;
        sel_codes[0]  = cfg_q.sel_lo;
        sel_codes[1]  = cfg_q.sel_hi;
    end

    for (genvar w = 0; w < N_WHEELS; w++) begin : g_wheel
        lm_wheel i_wheel (
            .cfg  (wheel_cfg[w]),
            .vars (wheel_vars[w]),
            .y    (wheel_y[w])
        );
    end

    for (genvar s = 0; s < N_SEL_PINS; s++) begin : g_sel
        lm_pin_src i_sel (
            .code (sel_codes[s]),
            .vars (sel_var),
            .pin  (sel_pins[s])
        );
    end

    always_comb begin
        sel_or = |sel_pins;
        f_comb = sel_or ? wheel_y[1] : wheel_y[0];
    end

    lm_seq_elem i_seq (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .d   (f_comb),
        .q   (q)
    );

    always_comb f_out = cfg_q.registered ? q : f_comb;

    // R7
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_q == cell_cfg_t'($past(cfg_wdata))))
        else $error("configuration word not loaded");

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q))
        else $error("configuration word changed without strobe");

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cfg_q == '0 && f_comb == 1'b0))
        else $error("reset did not clear configuration");

    // R9
    reg_out_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (cfg_q.registered && !cfg_we) |=> (f_out == $past(f_comb)))
        else $error("registered output not one edge behind");
endmodule

// File: tb/test_lm_cell.sv
`timescale 1ns/1ps
module test_lm_cell;
    localparam logic [1:0] Z = 2'd0, O = 2'd1, X = 2'd2, Y = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [16:0] cfg_wdata = '0;
    logic        clr = 1'b0;
    logic [1:0]  wa_var = '0, wb_var = '0, sel_var = '0;
    logic        f_comb, f_out;
    int          checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    lm_cell i_lm_cell (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .clr(clr), .wa_var(wa_var), .wb_var(wb_var), .sel_var(sel_var),
        .f_comb(f_comb), .f_out(f_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic logic [16:0] mk(input logic [1:0] a0, a1, sa, b0, b1, sb,
                                       s0, s1, input logic m);
        return {m, s1, s0, sb, b1, b0, sa, a1, a0};
    endfunction

    function automatic logic src(input logic [1:0] c, input logic [1:0] v);
        case (c)
            2'd0:    return 1'b0;
            2'd1:    return 1'b1;
            2'd2:    return v[0];
            default: return v[1];
        endcase
    endfunction

    function automatic logic model(input logic [16:0] c, input logic [1:0] wa,
                                   input logic [1:0] wb, input logic [1:0] sv);
        logic ma, mb, s;
        ma = src(c[5:4], wa) ? src(c[3:2], wa) : src(c[1:0], wa);
        mb = src(c[11:10], wb) ? src(c[9:8], wb) : src(c[7:6], wb);
        s  = src(c[13:12], sv) | src(c[15:14], sv);
        return s ? mb : ma;
    endfunction

    task automatic write_cfg(input logic [16:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [1:0] wa, input logic [1:0] wb, input logic [1:0] sv);
        wa_var = wa; wb_var = wb; sel_var = sv;
        #1;
    endtask

    initial begin
        #(100000 * 5);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [16:0] c;
        void'($urandom(32'd2024));
        // R8 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        drive(2'b11, 2'b11, 2'b11);
        chk("R8 f_comb after reset", f_comb, 1'b0);
        chk("R8 f_out after reset", f_out, 1'b0);
        rst = 1'b0;

        // R4 example function
        write_cfg(mk(X, O, Y, X, O, Y, Z, X, 1'b0));
        for (int n = 0; n < 16; n++) begin
            logic a, b, cc, d;
            {a, b, cc, d} = n[3:0];
            drive({cc, d}, {a, d}, {1'b0, b});
            chk("R4 example function", f_comb, (a & b) | (~b & cc) | d);
            chk("R11 comb mode output", f_out, f_comb);
        end

        // R2 source codes via wheel A data0, select constant 0
        for (int code = 0; code < 4; code++) begin
            write_cfg(mk(code[1:0], Z, Z, Z, Z, Z, Z, Z, 1'b0));
            for (int v = 0; v < 4; v++) begin
                drive(v[1:0], 2'b00, 2'b00);
                chk("R2 pin source code", f_comb,
                    code == 0 ? 1'b0 : code == 1 ? 1'b1 : code == 2 ? v[0] : v[1]);
            end
        end

        // R1 wheel data selection
        write_cfg(mk(X, Y, Z, Z, Z, Z, Z, Z, 1'b0));
        for (int v = 0; v < 4; v++) begin
            drive(v[1:0], 2'b00, 2'b00);
            chk("R1 select 0 picks data0", f_comb, v[0]);
        end
        write_cfg(mk(X, Y, O, Z, Z, Z, Z, Z, 1'b0));
        for (int v = 0; v < 4; v++) begin
            drive(v[1:0], 2'b00, 2'b00);
            chk("R1 select 1 picks data1", f_comb, v[1]);
        end

        // R3 OR of output selects
        write_cfg(mk(Z, Z, Z, O, O, Z, X, Y, 1'b0));
        for (int v = 0; v < 4; v++) begin
            drive(2'b00, 2'b00, v[1:0]);
            chk("R3 OR select", f_comb, v[0] | v[1]);
        end

        // R12 single wheel gates: x = A (bit0), y = B (bit1)
        for (int g = 0; g < 6; g++) begin
            logic [16:0] w;
            case (g)
                0: w = mk(O, Z, X, Z, Z, Z, Z, Z, 1'b0);
                1: w = mk(Z, O, X, Z, Z, Z, Z, Z, 1'b0);
                2: w = mk(Z, Y, X, Z, Z, Z, Z, Z, 1'b0);
                3: w = mk(Y, O, X, Z, Z, Z, Z, Z, 1'b0);
                4: w = mk(X, Z, Y, Z, Z, Z, Z, Z, 1'b0);
                default: w = mk(Y, Z, X, Z, Z, Z, Z, Z, 1'b0);
            endcase
            write_cfg(w);
            for (int v = 0; v < 4; v++) begin
                logic a, b, e;
                a = v[0]; b = v[1];
                case (g)
                    0: e = ~a;
                    1: e = a;
                    2: e = a & b;
                    3: e = a | b;
                    4: e = a & ~b;
                    default: e = ~a & b;
                endcase
                drive({b, a}, 2'b00, 2'b00);
                chk("R12 single wheel gate", f_comb, e);
            end
        end

        // R5 all 16 two-variable functions, truth index {A,B}
        for (int f = 0; f < 16; f++) begin
            write_cfg(mk({1'b0, f[0]}, {1'b0, f[1]}, X,
                         {1'b0, f[2]}, {1'b0, f[3]}, X, X, Z, 1'b0));
            for (int v = 0; v < 4; v++) begin
                logic a, b;
                {a, b} = v[1:0];
                drive({1'b0, b}, {1'b0, b}, {1'b0, a});
                chk("R5 sixteen functions", f_comb, f[{a, b}]);
            end
        end

        // R6 NAND
        write_cfg(mk(O, O, Z, O, Z, X, X, Z, 1'b0));
        for (int v = 0; v < 4; v++) begin
            logic a, b;
            {a, b} = v[1:0];
            drive(2'b00, {1'b0, b}, {1'b0, a});
            chk("R6 nand", f_comb, ~(a & b));
        end

        // R7 hold without strobe
        write_cfg(mk(O, O, Z, Z, Z, Z, Z, Z, 1'b0));
        @(negedge clk);
        cfg_wdata = '0;
        @(negedge clk);
        #1;
        chk("R7 config held without strobe", f_comb, 1'b1);

        // R9 registered mode
        write_cfg(mk(X, X, Z, Z, Z, Z, Z, Z, 1'b1));
        drive(2'b00, 2'b00, 2'b00);
        @(negedge clk); #1;
        chk("R9 registered zero", f_out, 1'b0);
        drive(2'b01, 2'b00, 2'b00);
        chk("R9 not yet clocked", f_out, 1'b0);
        chk("R9 comb ahead", f_comb, 1'b1);
        @(negedge clk); #1;
        chk("R9 captured one", f_out, 1'b1);
        write_cfg(mk(Z, Z, Z, Z, Z, Z, Z, Z, 1'b1));
        #1;
        chk("R9 old config captured at write edge", f_out, 1'b1);
        chk("R9 new config comb", f_comb, 1'b0);
        @(negedge clk); #1;
        chk("R9 new config captured", f_out, 1'b0);

        // R10 asynchronous clear
        write_cfg(mk(O, O, Z, Z, Z, Z, Z, Z, 1'b1));
        @(negedge clk); #1;
        chk("R10 stored one before clear", f_out, 1'b1);
        clr = 1'b1; #1;
        chk("R10 clear without edge", f_out, 1'b0);
        @(negedge clk); #1;
        chk("R10 clear beats edge", f_out, 1'b0);
        clr = 1'b0; #1;
        chk("R10 zero after release", f_out, 1'b0);
        @(negedge clk); #1;
        chk("R10 loads after release", f_out, 1'b1);

        // random configurations, combinational mode
        for (int i = 0; i < 300; i++) begin
            c = 17'($urandom);
            c[16] = 1'b0;
            write_cfg(c);
            for (int k = 0; k < 4; k++) begin
                logic [1:0] wa, wb, sv;
                wa = 2'($urandom); wb = 2'($urandom); sv = 2'($urandom);
                drive(wa, wb, sv);
                chk("R2 R3 random config", f_comb, model(c, wa, wb, sv));
                chk("R11 random comb mode", f_out, model(c, wa, wb, sv));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule